// File: doc/BRIEF.md
# Code Prefetch Queue

This block sits between instruction memory and a variable-length instruction decoder. It keeps a small circular store of code bytes, 16 by default, and keeps it topped up by asking memory for aligned 32-bit words whenever enough room is free. The room count includes the words already requested and not yet returned. The decoder sees the queue through two views. The first is the oldest byte, used to step through prefixes, opcodes and addressing bytes one at a time. The second is a little-endian 4-byte window that starts at that same byte, with a count of how many of its bytes are really present. In one cycle the decoder may remove 0 to 4 bytes, so a displacement or immediate of 1, 2 or 4 bytes leaves the queue in a single step.

A flush pulse, raised on branches, faults, interrupts or code-segment reloads, empties the queue in one cycle and restarts fetching at a new byte address. If that address is not word aligned, the fetch is aligned down and the bytes in front of the target are dropped when the word arrives. Words still in flight from before the flush are discarded as they return. This depends on memory answering requests in the order it accepted them.

The fetch request uses valid/ready. The request may be held off by memory for any number of cycles, and address and valid then stay unchanged unless a flush intervenes. The response carries a valid strobe but no ready, because the queue only issues a request once space for its whole word is already reserved. Every response is therefore accepted in the cycle it is offered.

Top module: `code_prefetch_queue`

## Requirements
- R1: While reset is held and in the first cycle after it, the queue is empty: `head_valid_o`=0 and `win_count_o`=0. `fetch_valid_o`=1 with `fetch_addr_o` equal to the reset address aligned down to 4.
- R2: `fetch_valid_o` is 1 exactly when (bytes stored) + 4 × (live requests outstanding) + 4 ≤ DEPTH and the total of outstanding requests, live and discarded, is below OUT_MAX. `fetch_addr_o` has bits [1:0] = 0 and advances by 4 after each accepted request (`fetch_valid_o` & `fetch_ready_i`).
- R3: An accepted response appends its bytes to the tail in little-endian order, so `resp_data_i[7:0]` is the first byte queued.
- R4: `head_byte_o` is the oldest byte. `head_valid_o`=1 when at least one byte is stored. `win_count_o` = min(bytes stored, 4). `win_data_o` bits [8k+7:8k] hold the k-th oldest byte for k < `win_count_o` and are 0 otherwise.
- R5: `take_i`=n (0..4) removes the n oldest bytes at the clock edge. From the next cycle the views start n bytes later.
- R6: `flush_i` empties the queue at the edge. In the following cycle `head_valid_o`=0, `win_count_o`=0 and `fetch_addr_o` = `flush_addr_i` with bits [1:0] cleared. A `take_i` in the flush cycle has no effect.
- R7: Responses to requests accepted before a flush, or in the flush cycle itself, are discarded and add no bytes.
- R8: After a restart at an address whose bits [1:0] = s, the first response queues only bytes s..3 of its word.
- R9: The number of stored bytes never exceeds DEPTH, and no accepted response is ever refused.
- R10: `take_i` must not exceed `win_count_o`, since that is the decoder's contract.
- R11: A take and an arriving response in the same cycle are both applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Empty the queue and restart fetching |
| flush_addr_i | input | AW | Byte address to restart at |
| fetch_valid_o | output | 1 | Fetch request valid |
| fetch_ready_i | input | 1 | Memory accepts the request |
| fetch_addr_o | output | AW | Word-aligned fetch address |
| resp_valid_i | input | 1 | Returned code word valid (always accepted) |
| resp_data_i | input | 32 | Returned code word, little-endian |
| head_valid_o | output | 1 | Oldest byte present |
| head_byte_o | output | 8 | Oldest byte |
| win_data_o | output | 32 | Four bytes starting at the oldest, little-endian |
| win_count_o | output | 3 | Number of valid window bytes, 0..4 |
| take_i | input | 3 | Bytes removed this cycle, 0..4 |

## Verification
The checker relies on its neighbours keeping two promises. The decoder never removes more bytes than the window reports. Memory returns words in request order and never offers a response with no request outstanding. The bench meets the first promise by choosing each take from the `win_count_o` it has just sampled. It meets the second with an in-order response list whose entries are created only by accepted requests, each with a due cycle no earlier than the one before. Flushes land at arbitrary byte addresses, sometimes while several words are in flight and sometimes in the same cycle as a request or a response, so the discard and unaligned-restart paths are reached from within these rules.

// File: rtl/cpq_pkg.sv
package cpq_pkg;
  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned WORD_BITS  = 8 * WORD_BYTES;
  typedef logic [7:0] code_byte_t;
  typedef logic [2:0] nbytes_t;
endpackage

// File: rtl/cpq_byte_ring.sv
module cpq_byte_ring
  import cpq_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clear_i,
  input  nbytes_t                       wr_n_i,
  input  logic [WORD_BITS-1:0]          wr_data_i,
  input  nbytes_t                       take_i,
  output logic [$clog2(DEPTH):0]        occ_o,
  output logic [WORD_BITS-1:0]          raw_o
);
  localparam int unsigned PW = $clog2(DEPTH);
  localparam int unsigned CW = PW + 1;

  code_byte_t      mem [DEPTH];
  logic [PW-1:0]   rd_q, wr_q;
  logic [CW-1:0]   occ_q;

  // pointer and occupancy state
  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      rd_q  <= '0;
      wr_q  <= '0;
      occ_q <= '0;
    end else begin
      wr_q  <= wr_q + PW'(wr_n_i);
      rd_q  <= rd_q + PW'(take_i);
      occ_q <= occ_q + CW'(wr_n_i) - CW'(take_i);
    end
  end

  // byte storage, no reset needed
  always_ff @(posedge clk) begin
    if (rst_n && !clear_i) begin
      for (int i = 0; i < WORD_BYTES; i++) begin
        if (nbytes_t'(i) < wr_n_i)
          mem[wr_q + PW'(i)] <= wr_data_i[8*i +: 8];
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < WORD_BYTES; g++) begin : g_rd
      assign raw_o[8*g +: 8] = mem[rd_q + PW'(g)];
    end
  endgenerate

  assign occ_o = occ_q;
endmodule

// File: rtl/cpq_window.sv
module cpq_window
  import cpq_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic [$clog2(DEPTH):0]  occ_i,
  input  logic [WORD_BITS-1:0]    raw_i,
  output logic                    head_valid_o,
  output code_byte_t              head_byte_o,
  output logic [WORD_BITS-1:0]    win_data_o,
  output nbytes_t                 win_count_o
);
  localparam int unsigned CW = $clog2(DEPTH) + 1;

  always_comb begin
    if (occ_i >= CW'(WORD_BYTES)) win_count_o = nbytes_t'(WORD_BYTES);
    else                          win_count_o = nbytes_t'(occ_i);
  end

  assign head_valid_o = (occ_i != '0);
  assign head_byte_o  = head_valid_o ? raw_i[7:0] : 8'h00;

  genvar g;
  generate
    for (g = 0; g < WORD_BYTES; g++) begin : g_mask
      assign win_data_o[8*g +: 8] = (win_count_o > nbytes_t'(g)) ? raw_i[8*g +: 8] : 8'h00;
    end
  endgenerate
endmodule

// File: rtl/cpq_fetch_ctrl.sv
module cpq_fetch_ctrl
  import cpq_pkg::*;
#(
  parameter int unsigned    AW         = 32,
  parameter int unsigned    DEPTH      = 16,
  parameter int unsigned    OUT_MAX    = 4,
  parameter logic [AW-1:0]  RESET_ADDR = '0
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           flush_i,
  input  logic [AW-1:0]                  flush_addr_i,
  input  logic [$clog2(DEPTH):0]         occ_i,
  output logic                           fetch_valid_o,
  input  logic                           fetch_ready_i,
  output logic [AW-1:0]                  fetch_addr_o,
  input  logic                           resp_valid_i,
  input  logic [WORD_BITS-1:0]           resp_data_i,
  output nbytes_t                        wr_n_o,
  output logic [WORD_BITS-1:0]           wr_data_o,
  output logic [$clog2(OUT_MAX+1)-1:0]   live_o,
  output logic [$clog2(OUT_MAX+1)-1:0]   stale_o
);
  localparam int unsigned CW = $clog2(DEPTH) + 1;
  localparam int unsigned OW = $clog2(OUT_MAX + 1);
  localparam int unsigned SW = CW + OW + 3;

  logic [AW-3:0] nf_q;
  logic [OW-1:0] live_q, stale_q;
  logic          first_q;
  logic [1:0]    skip_q, skip_eff;
  logic [SW-1:0] need;
  logic          room_ok, slots_ok, req_fire, resp_live;

  always_comb begin
    need      = SW'(occ_i) + (SW'(live_q) << 2) + SW'(WORD_BYTES);
    room_ok   = (need <= SW'(DEPTH));
    slots_ok  = ((OW+1)'(live_q) + (OW+1)'(stale_q)) < (OW+1)'(OUT_MAX);
    fetch_valid_o = room_ok && slots_ok;
    req_fire  = fetch_valid_o && fetch_ready_i;
    resp_live = resp_valid_i && (stale_q == '0) && !flush_i;
    skip_eff  = first_q ? skip_q : 2'd0;
    wr_n_o    = resp_live ? (nbytes_t'(WORD_BYTES) - nbytes_t'(skip_eff)) : '0;
    wr_data_o = resp_data_i >> {skip_eff, 3'b000};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nf_q    <= RESET_ADDR[AW-1:2];
      live_q  <= '0;
      stale_q <= '0;
      first_q <= 1'b1;
      skip_q  <= RESET_ADDR[1:0];
    end else if (flush_i) begin
      // everything in flight, including a request taken this cycle, goes stale
      stale_q <= stale_q + live_q + OW'(req_fire) - OW'(resp_valid_i);
      live_q  <= '0;
      nf_q    <= flush_addr_i[AW-1:2];
      first_q <= 1'b1;
      skip_q  <= flush_addr_i[1:0];
    end else begin
      if (req_fire) nf_q <= nf_q + 1'b1;
      if (resp_valid_i && stale_q != '0) stale_q <= stale_q - 1'b1;
      live_q <= live_q + OW'(req_fire) - OW'(resp_valid_i && stale_q == '0);
      if (resp_live) first_q <= 1'b0;
    end
  end

  assign fetch_addr_o = {nf_q, 2'b00};
  assign live_o       = live_q;
  assign stale_o      = stale_q;
endmodule

// File: rtl/code_prefetch_queue.sv
module code_prefetch_queue
  import cpq_pkg::*;
#(
  parameter int unsigned    AW         = 32,
  parameter int unsigned    DEPTH      = 16,
  parameter int unsigned    OUT_MAX    = 4,
  parameter logic [AW-1:0]  RESET_ADDR = 32'h0000_FFF0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           flush_i,
  input  logic [AW-1:0]  flush_addr_i,
  output logic           fetch_valid_o,
  input  logic           fetch_ready_i,
  output logic [AW-1:0]  fetch_addr_o,
  input  logic           resp_valid_i,
  input  logic [31:0]    resp_data_i,
  output logic           head_valid_o,
  output logic [7:0]     head_byte_o,
  output logic [31:0]    win_data_o,
  output logic [2:0]     win_count_o,
  input  logic [2:0]     take_i
);
  localparam int unsigned CW = $clog2(DEPTH) + 1;
  localparam int unsigned OW = $clog2(OUT_MAX + 1);

  logic [CW-1:0]        occ;
  logic [WORD_BITS-1:0] raw;
  nbytes_t              wr_n;
  logic [WORD_BITS-1:0] wr_data;
  logic [OW-1:0]        live_cnt, stale_cnt;
  nbytes_t              take_eff;

  assign take_eff = flush_i ? '0 : take_i;

  cpq_fetch_ctrl #(
    .AW(AW), .DEPTH(DEPTH), .OUT_MAX(OUT_MAX), .RESET_ADDR(RESET_ADDR)
  ) u_fetch (
    .clk(clk), .rst_n(rst_n),
    .flush_i(flush_i), .flush_addr_i(flush_addr_i),
    .occ_i(occ),
    .fetch_valid_o(fetch_valid_o), .fetch_ready_i(fetch_ready_i), .fetch_addr_o(fetch_addr_o),
    .resp_valid_i(resp_valid_i), .resp_data_i(resp_data_i),
    .wr_n_o(wr_n), .wr_data_o(wr_data),
    .live_o(live_cnt), .stale_o(stale_cnt)
  );

  cpq_byte_ring #(.DEPTH(DEPTH)) u_ring (
    .clk(clk), .rst_n(rst_n), .clear_i(flush_i),
    .wr_n_i(wr_n), .wr_data_i(wr_data), .take_i(take_eff),
    .occ_o(occ), .raw_o(raw)
  );

  cpq_window #(.DEPTH(DEPTH)) u_view (
    .occ_i(occ), .raw_i(raw),
    .head_valid_o(head_valid_o), .head_byte_o(head_byte_o),
    .win_data_o(win_data_o), .win_count_o(win_count_o)
  );
endmodule

// File: rtl/cpq_checker.sv
module cpq_checker #(
  parameter int unsigned AW      = 32,
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned OUT_MAX = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          flush_i,
  input logic [AW-1:0]                 flush_addr_i,
  input logic                          fetch_valid_o,
  input logic                          fetch_ready_i,
  input logic [AW-1:0]                 fetch_addr_o,
  input logic                          resp_valid_i,
  input logic                          head_valid_o,
  input logic [2:0]                    win_count_o,
  input logic [2:0]                    take_i,
  input logic [$clog2(DEPTH):0]        occ,
  input logic [$clog2(OUT_MAX+1)-1:0]  live_cnt,
  input logic [$clog2(OUT_MAX+1)-1:0]  stale_cnt
);
  p_fetch_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid_o |-> fetch_addr_o[1:0] == 2'b00);

  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid_o && !fetch_ready_i && !flush_i) |=> (fetch_valid_o && $stable(fetch_addr_o)));

  p_flush_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (!head_valid_o && win_count_o == 3'd0));

  p_flush_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> fetch_addr_o[AW-1:2] == $past(flush_addr_i[AW-1:2]));

  p_resp_expected_r7: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid_i |-> (live_cnt != '0 || stale_cnt != '0));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= ($clog2(DEPTH)+1)'(DEPTH));

  p_take_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    take_i <= win_count_o);
endmodule

bind code_prefetch_queue cpq_checker #(.AW(AW), .DEPTH(DEPTH), .OUT_MAX(OUT_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .flush_addr_i(flush_addr_i),
  .fetch_valid_o(fetch_valid_o), .fetch_ready_i(fetch_ready_i), .fetch_addr_o(fetch_addr_o),
  .resp_valid_i(resp_valid_i), .head_valid_o(head_valid_o), .win_count_o(win_count_o),
  .take_i(take_i), .occ(occ), .live_cnt(live_cnt), .stale_cnt(stale_cnt)
);

// File: tb/code_prefetch_queue_tb.sv
module code_prefetch_queue_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam int OUT_MAX    = 4;
  localparam logic [31:0] RST_ADDR = 32'h0000_FFF0;
  localparam int RUN_CYCLES = 12000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        flush_i;
  logic [31:0] flush_addr_i;
  logic        fetch_valid_o, fetch_ready_i;
  logic [31:0] fetch_addr_o;
  logic        resp_valid_i;
  logic [31:0] resp_data_i;
  logic        head_valid_o;
  logic [7:0]  head_byte_o;
  logic [31:0] win_data_o;
  logic [2:0]  win_count_o, take_i;

  always #(CLK_PERIOD/2) clk = ~clk;

  code_prefetch_queue #(.DEPTH(DEPTH), .OUT_MAX(OUT_MAX), .RESET_ADDR(RST_ADDR)) u_dut (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .flush_addr_i(flush_addr_i),
    .fetch_valid_o(fetch_valid_o), .fetch_ready_i(fetch_ready_i), .fetch_addr_o(fetch_addr_o),
    .resp_valid_i(resp_valid_i), .resp_data_i(resp_data_i),
    .head_valid_o(head_valid_o), .head_byte_o(head_byte_o),
    .win_data_o(win_data_o), .win_count_o(win_count_o), .take_i(take_i)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  // reference model state
  logic [7:0]  q[$];
  logic [31:0] mq_addr[$];
  int          mq_epoch[$];
  int          mq_skip[$];
  int          mq_due[$];
  int          epoch = 0;
  bit          first = 1;
  int          skip  = int'(RST_ADDR[1:0]);
  logic [31:0] nf    = {RST_ADDR[31:2], 2'b00};
  int          cyc   = 0;
  int          last_due = 0;
  string       ctx = "R4";

  function automatic logic [7:0] code_at(logic [31:0] a);
    logic [31:0] t;
    t = a * 32'd13 + (a >> 8) + 32'h5A;
    return t[7:0];
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual %h expected %h", req, cyc, act, exp);
    end
  endtask

  function automatic int live_count();
    int n = 0;
    foreach (mq_epoch[i]) if (mq_epoch[i] == epoch) n++;
    return n;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    bit exp_fv;
    int wc, mode;
    rst_n = 1'b0; flush_i = 0; flush_addr_i = 0; fetch_ready_i = 0;
    resp_valid_i = 0; resp_data_i = 0; take_i = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!head_valid_o && win_count_o == 0, "R1 empty in reset", {31'd0, head_valid_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(fetch_valid_o == 1'b1, "R1 fetch after reset", {31'd0, fetch_valid_o}, 1);
    chk(fetch_addr_o == {RST_ADDR[31:2], 2'b00}, "R1 reset address", fetch_addr_o, {RST_ADDR[31:2], 2'b00});
    chk(!head_valid_o && win_count_o == 0, "R1 empty after reset", {29'd0, win_count_o}, 0);

    for (int c = 0; c < RUN_CYCLES; c++) begin
      if (c != 0) @(negedge clk);
      // compare against the model
      wc = (q.size() < 4) ? q.size() : 4;
      exp_fv = (q.size() + 4*live_count() + 4 <= DEPTH) && (mq_addr.size() < OUT_MAX);
      chk(head_valid_o == (q.size() != 0), {ctx, " head_valid"}, {31'd0, head_valid_o}, {31'd0, q.size() != 0});
      if (q.size() != 0) chk(head_byte_o == q[0], {ctx, " head byte"}, {24'd0, head_byte_o}, {24'd0, q[0]});
      chk(int'(win_count_o) == wc, {ctx, " window count"}, {29'd0, win_count_o}, wc);
      for (int k = 0; k < 4; k++) begin
        if (k < wc) chk(win_data_o[8*k +: 8] == q[k], {ctx, " window byte"}, {24'd0, win_data_o[8*k +: 8]}, {24'd0, q[k]});
        else chk(win_data_o[8*k +: 8] == 8'h00, "R4 unused window byte", {24'd0, win_data_o[8*k +: 8]}, 0);
      end
      chk(fetch_valid_o == exp_fv, "R2 fetch_valid", {31'd0, fetch_valid_o}, {31'd0, exp_fv});
      if (exp_fv) chk(fetch_addr_o == nf, "R2 fetch address", fetch_addr_o, nf);

      // drive next inputs
      mode = (c / 400) % 4;
      fetch_ready_i = ($urandom_range(0, 3) != 0);
      if (mq_addr.size() != 0 && mq_due[0] <= cyc) begin
        resp_valid_i = 1'b1;
        resp_data_i  = {code_at(mq_addr[0]+3), code_at(mq_addr[0]+2), code_at(mq_addr[0]+1), code_at(mq_addr[0])};
      end else begin
        resp_valid_i = 1'b0;
        resp_data_i  = $urandom;
      end
      case (mode)
        1: take_i = 3'd0;
        2: take_i = 3'(wc);
        default: take_i = 3'($urandom_range(0, wc));
      endcase
      flush_i = (mode == 3) ? ($urandom_range(0, 7) == 0) : ($urandom_range(0, 63) == 0);
      flush_addr_i = 32'h0002_0000 + $urandom_range(0, 4095);

      // choose the tag for the next comparison
      if (flush_i) ctx = "R6";
      else if (resp_valid_i && mq_epoch[0] != epoch) ctx = "R7";
      else if (resp_valid_i && mq_skip[0] != 0) ctx = "R8";
      else if (resp_valid_i && take_i != 0) ctx = "R11";
      else if (take_i != 0) ctx = "R5";
      else if (resp_valid_i) ctx = "R3";
      else ctx = "R4";

      @(posedge clk);
      cyc++;
      // model update with the values just applied
      for (int k = 0; k < int'(take_i); k++) if (!flush_i) void'(q.pop_front());
      if (resp_valid_i) begin
        if (mq_epoch[0] == epoch)
          for (int k = mq_skip[0]; k < 4; k++) q.push_back(code_at(mq_addr[0] + k));
        void'(mq_addr.pop_front()); void'(mq_epoch.pop_front());
        void'(mq_skip.pop_front()); void'(mq_due.pop_front());
      end
      if (exp_fv && fetch_ready_i) begin
        mq_addr.push_back(nf);
        mq_epoch.push_back(epoch);
        mq_skip.push_back(first ? skip : 0);
        last_due = (cyc + $urandom_range(0, 5) > last_due + 1) ? cyc + $urandom_range(0, 5) : last_due + 1;
        mq_due.push_back(last_due);
        nf = nf + 4;
        first = 0;
      end
      if (flush_i) begin
        q.delete();
        epoch++;
        nf = {flush_addr_i[31:2], 2'b00};
        first = 1;
        skip = int'(flush_addr_i[1:0]);
      end
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule